// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block is the microsequencer that a small 16-bit processor core hands control to when it takes or leaves a vectored interrupt. The core raises a one-cycle `boundary` strobe between instructions. Only on that strobe, and only while the sequencer is idle, does the block look at its request inputs. These are a software trigger that carries its own type number, a non-maskable line, a maskable line, and an interrupt-return request. Because requests are looked at only on the strobe, an instruction is never cut off midway.

For an entry, the block first copies the core's flags, code segment, instruction pointer, stack segment and stack pointer. For a maskable request it then asks the device for an 8-bit type number. It pushes three words onto the stack in memory and reads the new offset and segment from a vector table at the bottom of the address space. It then writes the new state back to the core in a single cycle. A return pops the saved words in the reverse order. No other request is accepted until the sequence has finished.

The device type number arrives over a valid/ready stream. `irq_ack` is the ready signal, and a type is taken on the clock edge where `irq_type_valid` and `irq_ack` are both high. The device may hold `irq_type_valid` low for as long as it needs. The memory port is a request/ready handshake. The block holds `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ready` is sampled high, so the memory can stall for any number of cycles.

Top module: `irq_seq`

## Requirements
- R1: A request is accepted only on a clock edge where `boundary` is high and the block is idle. `busy` goes high in the cycle after that edge, and a request held without `boundary` starts nothing.
- R2: After a maskable request is accepted, `irq_ack` stays high until the edge where `irq_type_valid` is high. The type on `irq_type` at that edge is the type used for the vector fetch.
- R3: On entry the block writes three words to memory: the flags, then the code segment, then the instruction pointer. Each word goes to stack address SP-2, SP-4 and SP-6 in turn, so the pointer drops by 2 before each write.
- R4: At the end of entry, `flags_out` is the saved flags with bit 9 (interrupt enable) and bit 8 (trace) cleared, and `sp_out` is the entry SP minus 6.
- R5: On entry the block reads the new offset at address 4×type and then the new segment at 4×type+2. These become `ip_out` and `cs_out`. For example, type 0x21 reads 0x00084 and then 0x00086.
- R6: The maskable request is ignored when bit 9 of `flags_in` is 0. The non-maskable request is serviced whatever that bit is, and it uses type 2.
- R7: When several requests are present at the same boundary, the software trigger wins first, then the non-maskable request, then the maskable request, then return. A request that loses raises no `irq_ack`.
- R8: A return reads the instruction pointer at SP, the code segment at SP+2 and the flags at SP+4. It writes those values to `ip_out`, `cs_out` and `flags_out`, and writes SP+6 to `sp_out`.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R10: While `busy` is high, every request and `boundary` strobe is ignored, and only one sequence's memory accesses take place.
- R11: `done` is a one-cycle pulse in the same cycle that `flags_we`, `cs_we`, `ip_we` and `sp_we` are all high. `busy` is low in the cycle after it. After reset, `busy`, `done`, `mem_valid` and `irq_ack` are low.
- R12: A stack address is 16×SS plus the stack pointer, kept to 20 bits. An address that runs past 0xFFFFF wraps to the bottom of memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| swi_req | input | 1 | Software interrupt trigger |
| swi_type | input | 8 | Type number carried by the software interrupt |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | 1 | Maskable request |
| irq_ack | output | 1 | Acknowledge; also ready for the type stream |
| irq_type_valid | input | 1 | Device type number is valid |
| irq_type | input | 8 | Device type number |
| ret_req | input | 1 | Interrupt-return request |
| flags_in | input | 16 | Current flags of the core |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| flags_out | output | 16 | Flags value to load |
| flags_we | output | 1 | Load strobe for flags |
| cs_out | output | 16 | Code segment to load |
| cs_we | output | 1 | Load strobe for the code segment |
| ip_out | output | 16 | Instruction pointer to load |
| ip_we | output | 1 | Load strobe for the instruction pointer |
| sp_out | output | 16 | Stack pointer to load |
| sp_we | output | 1 | Load strobe for the stack pointer |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory has completed the access this cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when `mem_ready` is high |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | The sequence finishes this cycle |

## Verification
The assertions assume several things about the inputs. The core raises `boundary` only between instructions. The core does not raise the software trigger and the return request at the same strobe. The memory returns `mem_rdata` in the same cycle as `mem_ready`. The device eventually raises `irq_type_valid` once it has been acknowledged.

The stimulus respects all of these. Every input is driven on the falling edge. Each request is held for exactly the one `boundary` cycle, or for a few cycles with no strobe when R1 is being tested. The memory model inserts zero to two wait cycles before each ready, and the device answers the acknowledge in the next cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACK,
    S_PUSH_F,
    S_PUSH_CS,
    S_PUSH_IP,
    S_RD_OFF,
    S_RD_SEG,
    S_LOAD,
    S_POP_IP,
    S_POP_CS,
    S_POP_F,
    S_RLOAD
  } seq_state_t;

  typedef enum logic [2:0] {
    K_NONE,
    K_SWI,
    K_NMI,
    K_IRQ,
    K_RET
  } req_kind_t;

  typedef enum logic [1:0] {
    A_PUSH,
    A_POP,
    A_VOFF,
    A_VSEG
  } addr_sel_t;

endpackage

// File: rtl/irq_seq_arb.sv
// Boundary sampling and fixed priority among the request sources.
module irq_seq_arb
  import irq_seq_pkg::*;
#(
  parameter int TW = 8,
  parameter logic [TW-1:0] NMI_TYPE = TW'(2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          boundary,
  input  logic          swi_req,
  input  logic [TW-1:0] swi_type,
  input  logic          nmi_req,
  input  logic          irq_req,
  input  logic          ret_req,
  input  logic          if_flag,
  output logic          take,
  output req_kind_t     kind,
  output logic [TW-1:0] take_type
);

  always_comb begin
    kind      = K_NONE;
    take_type = swi_type;
    if (swi_req) begin
      kind = K_SWI;
    end else if (nmi_req) begin
      kind      = K_NMI;
      take_type = NMI_TYPE;
    end else if (irq_req && if_flag) begin
      kind = K_IRQ;
    end else if (ret_req) begin
      kind = K_RET;
    end
  end

  assign take = idle && boundary && (kind != K_NONE);

  // R6: a masked maskable request alone never wins
  a_r6_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !if_flag && !swi_req && !nmi_req && !ret_req) |-> !take);

  // R7: a software trigger always beats the non-maskable request
  a_r7_swi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take && swi_req) |-> (kind == K_SWI));

endmodule

// File: rtl/irq_seq_addr.sv
// Physical address former for stack and vector-table accesses.
module irq_seq_addr
  import irq_seq_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 20,
  parameter int TW = 8
) (
  input  addr_sel_t     sel,
  input  logic [W-1:0]  ss,
  input  logic [W-1:0]  sp,
  input  logic [TW-1:0] vtype,
  output logic [AW-1:0] addr
);

  localparam int SEG_SHIFT = AW - W;
  localparam int STEP      = W / 8;
  localparam int VSHIFT    = $clog2(2 * STEP);
  localparam int VPAD      = AW - TW - VSHIFT;

  logic [W-1:0]  sp_eff;
  logic [AW-1:0] stack_pa;
  logic [AW-1:0] vec_base;

  always_comb begin
    sp_eff   = (sel == A_PUSH) ? (sp - W'(STEP)) : sp;
    stack_pa = {ss, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, sp_eff};
    vec_base = {{VPAD{1'b0}}, vtype, {VSHIFT{1'b0}}};
    unique case (sel)
      A_VOFF:  addr = vec_base;
      A_VSEG:  addr = vec_base + AW'(STEP);
      default: addr = stack_pa;
    endcase
  end

endmodule

// File: rtl/irq_seq.sv
// Vectored interrupt entry / return sequencer.
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int W        = 16,
  parameter int AW       = 20,
  parameter int TW       = 8,
  parameter int NMI_TYPE = 2,
  parameter int IF_BIT   = 9,
  parameter int TF_BIT   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          swi_req,
  input  logic [TW-1:0] swi_type,
  input  logic          nmi_req,
  input  logic          irq_req,
  output logic          irq_ack,
  input  logic          irq_type_valid,
  input  logic [TW-1:0] irq_type,
  input  logic          ret_req,
  input  logic [W-1:0]  flags_in,
  input  logic [W-1:0]  cs_in,
  input  logic [W-1:0]  ip_in,
  input  logic [W-1:0]  ss_in,
  input  logic [W-1:0]  sp_in,
  output logic [W-1:0]  flags_out,
  output logic          flags_we,
  output logic [W-1:0]  cs_out,
  output logic          cs_we,
  output logic [W-1:0]  ip_out,
  output logic          ip_we,
  output logic [W-1:0]  sp_out,
  output logic          sp_we,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy,
  output logic          done
);

  localparam int STEP = W / 8;
  localparam logic [W-1:0] CLR_MASK = ~((W'(1) << IF_BIT) | (W'(1) << TF_BIT));
  localparam int VPAD = AW - TW - 2;

  seq_state_t    state, state_nx;
  logic [TW-1:0] type_q;
  logic [W-1:0]  ss_q, sp_q, fl_q, cs_q, ip_q;
  logic          take, hs;
  req_kind_t     kind;
  logic [TW-1:0] take_type;
  addr_sel_t     asel;

  irq_seq_arb #(.TW(TW), .NMI_TYPE(TW'(NMI_TYPE))) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (state == S_IDLE),
    .boundary  (boundary),
    .swi_req   (swi_req),
    .swi_type  (swi_type),
    .nmi_req   (nmi_req),
    .irq_req   (irq_req),
    .ret_req   (ret_req),
    .if_flag   (flags_in[IF_BIT]),
    .take      (take),
    .kind      (kind),
    .take_type (take_type)
  );

  always_comb begin
    unique case (state)
      S_PUSH_F, S_PUSH_CS, S_PUSH_IP: asel = A_PUSH;
      S_RD_OFF:                       asel = A_VOFF;
      S_RD_SEG:                       asel = A_VSEG;
      default:                        asel = A_POP;
    endcase
  end

  irq_seq_addr #(.W(W), .AW(AW), .TW(TW)) u_addr (
    .sel   (asel),
    .ss    (ss_q),
    .sp    (sp_q),
    .vtype (type_q),
    .addr  (mem_addr)
  );

  // memory side
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state)
      S_PUSH_F:  begin mem_valid = 1'b1; mem_we = 1'b1; mem_wdata = fl_q; end
      S_PUSH_CS: begin mem_valid = 1'b1; mem_we = 1'b1; mem_wdata = cs_q; end
      S_PUSH_IP: begin mem_valid = 1'b1; mem_we = 1'b1; mem_wdata = ip_q; end
      S_RD_OFF, S_RD_SEG, S_POP_IP, S_POP_CS, S_POP_F: mem_valid = 1'b1;
      default: ;
    endcase
  end

  assign hs = mem_valid && mem_ready;

  // next state
  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE: if (take) begin
        unique case (kind)
          K_IRQ:   state_nx = S_ACK;
          K_RET:   state_nx = S_POP_IP;
          default: state_nx = S_PUSH_F;
        endcase
      end
      S_ACK:     if (irq_type_valid) state_nx = S_PUSH_F;
      S_PUSH_F:  if (hs) state_nx = S_PUSH_CS;
      S_PUSH_CS: if (hs) state_nx = S_PUSH_IP;
      S_PUSH_IP: if (hs) state_nx = S_RD_OFF;
      S_RD_OFF:  if (hs) state_nx = S_RD_SEG;
      S_RD_SEG:  if (hs) state_nx = S_LOAD;
      S_POP_IP:  if (hs) state_nx = S_POP_CS;
      S_POP_CS:  if (hs) state_nx = S_POP_F;
      S_POP_F:   if (hs) state_nx = S_RLOAD;
      default:   state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      type_q <= '0;
      ss_q   <= '0;
      sp_q   <= '0;
      fl_q   <= '0;
      cs_q   <= '0;
      ip_q   <= '0;
    end else begin
      state <= state_nx;
      if (state == S_IDLE && take) begin
        type_q <= take_type;
        ss_q   <= ss_in;
        sp_q   <= sp_in;
        fl_q   <= flags_in;
        cs_q   <= cs_in;
        ip_q   <= ip_in;
      end
      if (state == S_ACK && irq_type_valid) type_q <= irq_type;
      if (hs) begin
        unique case (state)
          S_PUSH_F, S_PUSH_CS, S_PUSH_IP: sp_q <= sp_q - W'(STEP);
          S_RD_OFF: ip_q <= mem_rdata;
          S_RD_SEG: cs_q <= mem_rdata;
          S_POP_IP: begin ip_q <= mem_rdata; sp_q <= sp_q + W'(STEP); end
          S_POP_CS: begin cs_q <= mem_rdata; sp_q <= sp_q + W'(STEP); end
          S_POP_F:  begin fl_q <= mem_rdata; sp_q <= sp_q + W'(STEP); end
          default: ;
        endcase
      end
    end
  end

  // register write-back and status
  assign done      = (state == S_LOAD) || (state == S_RLOAD);
  assign flags_we  = done;
  assign cs_we     = done;
  assign ip_we     = done;
  assign sp_we     = done;
  assign flags_out = (state == S_LOAD) ? (fl_q & CLR_MASK) : fl_q;
  assign cs_out    = cs_q;
  assign ip_out    = ip_q;
  assign sp_out    = sp_q;
  assign busy      = (state != S_IDLE);
  assign irq_ack   = (state == S_ACK);

  // R1: a sequence starts only after a boundary strobe
  a_r1_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(boundary));

  // R2: acknowledge only while waiting for the type, never with memory traffic
  a_r2_ack_alone: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (busy && !mem_valid && !done));

  // R4: entry write-back has enable and trace cleared
  a_r4_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && state != S_RLOAD) |-> (!flags_out[IF_BIT] && !flags_out[TF_BIT]));

  // R5: vector reads stay inside the table
  a_r5_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && (state == S_RD_OFF || state == S_RD_SEG))
      |-> (mem_addr[AW-1:AW-VPAD] == '0 && !mem_we));

  // R9: request held steady under back-pressure
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_wdata)));

  // R10: no new acceptance while a sequence runs
  a_r10_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R11: done is a single pulse followed by idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

// File: tb/sim_irq_seq.sv
`timescale 1ns/1ps
module sim_irq_seq;

  typedef struct {
    logic        we;
    logic [19:0] addr;
    logic [15:0] data;
    string       tag;
  } mem_item_t;

  typedef struct {
    logic [15:0] ip;
    logic [15:0] cs;
    logic [15:0] fl;
    logic [15:0] sp;
    string       tag;
  } reg_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic boundary, swi_req, nmi_req, irq_req, ret_req, irq_type_valid;
  logic [7:0] swi_type, irq_type;
  logic [15:0] flags_in, cs_in, ip_in, ss_in, sp_in;
  logic [15:0] flags_out, cs_out, ip_out, sp_out, mem_wdata;
  logic [15:0] mem_rdata;
  logic flags_we, cs_we, ip_we, sp_we, mem_valid, mem_we, busy, done, irq_ack;
  logic mem_ready;
  logic [19:0] mem_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int wait_cnt = 0;
  int seed     = 0;
  mem_item_t exp_mem[$];
  reg_item_t exp_reg[$];

  always #2.5 clk = ~clk;

  irq_seq u0 (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .swi_req(swi_req), .swi_type(swi_type), .nmi_req(nmi_req),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_type_valid(irq_type_valid),
    .irq_type(irq_type), .ret_req(ret_req),
    .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
    .flags_out(flags_out), .flags_we(flags_we), .cs_out(cs_out), .cs_we(cs_we),
    .ip_out(ip_out), .ip_we(ip_we), .sp_out(sp_out), .sp_we(sp_we),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] ss, input logic [15:0] sp);
    return {ss, 4'h0} + {4'h0, sp};
  endfunction

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    mem_ready = 1'b0;
    if (rst_n && mem_valid) begin
      if (wait_cnt > 0) begin
        wait_cnt--;
      end else if (exp_mem.size() == 0) begin
        chk(1'b0, "R10 unexpected memory access", {12'h0, mem_addr}, 32'h0);
        mem_ready = 1'b1;
      end else begin
        mem_item_t e;
        e = exp_mem.pop_front();
        chk(mem_we == e.we && mem_addr == e.addr, {e.tag, " address/direction"},
            {11'h0, mem_we, mem_addr}, {11'h0, e.we, e.addr});
        if (e.we) chk(mem_wdata == e.data, {e.tag, " write data"}, {16'h0, mem_wdata}, {16'h0, e.data});
        mem_rdata = e.we ? 16'h0 : e.data;
        mem_ready = 1'b1;
        seed++;
        wait_cnt = seed % 3;
      end
    end
  end

  // write-back monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_reg.size() == 0) begin
        chk(1'b0, "R10 unexpected completion", 32'h0, 32'h0);
      end else begin
        reg_item_t r;
        r = exp_reg.pop_front();
        chk(flags_we && cs_we && ip_we && sp_we, "R11 all strobes with done",
            {28'h0, flags_we, cs_we, ip_we, sp_we}, 32'hF);
        chk(ip_out == r.ip, {r.tag, " ip_out"}, {16'h0, ip_out}, {16'h0, r.ip});
        chk(cs_out == r.cs, {r.tag, " cs_out"}, {16'h0, cs_out}, {16'h0, r.cs});
        chk(flags_out == r.fl, {r.tag, " flags_out"}, {16'h0, flags_out}, {16'h0, r.fl});
        chk(sp_out == r.sp, {r.tag, " sp_out"}, {16'h0, sp_out}, {16'h0, r.sp});
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog expired", cyc, 100000);
      finish_run();
    end
  end

  // kind: 0 software, 1 non-maskable, 2 maskable
  task automatic run_entry(input int kind, input logic [7:0] t, input logic [15:0] fl,
                           input logic [15:0] cs, input logic [15:0] ip,
                           input logic [15:0] ss, input logic [15:0] sp,
                           input bit also_nmi, input bit also_irq, input bit poke,
                           input string tag);
    logic [7:0]  vt;
    logic [15:0] off, seg;
    vt  = (kind == 1) ? 8'h02 : t;
    off = {vt, 8'h5A} ^ 16'h1111;
    seg = {8'hC0, vt};
    exp_mem.push_back('{1'b1, phys(ss, sp - 16'd2), fl, "R3 push flags"});
    exp_mem.push_back('{1'b1, phys(ss, sp - 16'd4), cs, "R3 push cs"});
    exp_mem.push_back('{1'b1, phys(ss, sp - 16'd6), ip, "R3 push ip"});
    exp_mem.push_back('{1'b0, {10'h0, vt, 2'b00}, off, "R5 offset read"});
    exp_mem.push_back('{1'b0, {10'h0, vt, 2'b00} + 20'd2, seg, "R5 segment read"});
    exp_reg.push_back('{off, seg, fl & 16'hFCFF, sp - 16'd6, {tag, " R4"}});
    @(negedge clk);
    flags_in = fl; cs_in = cs; ip_in = ip; ss_in = ss; sp_in = sp;
    swi_req  = (kind == 0); swi_type = t;
    nmi_req  = (kind == 1) || also_nmi;
    irq_req  = (kind == 2) || also_irq;
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0; swi_req = 1'b0; nmi_req = 1'b0; irq_req = 1'b0;
    chk(busy == 1'b1, {tag, " R1 busy after boundary"}, {31'h0, busy}, 1);
    chk(irq_ack == (kind == 2), {tag, " R2/R7 acknowledge"}, {31'h0, irq_ack}, (kind == 2));
    if (kind == 2) begin
      irq_type_valid = 1'b1; irq_type = t;
      @(negedge clk);
      irq_type_valid = 1'b0; irq_type = 8'hEE;
      chk(irq_ack == 1'b0, {tag, " R2 ack drops after type"}, {31'h0, irq_ack}, 0);
    end
    if (poke) begin
      nmi_req = 1'b1; irq_req = 1'b1; boundary = 1'b1;
      @(negedge clk);
      nmi_req = 1'b0; irq_req = 1'b0; boundary = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, {tag, " R10/R11 idle after sequence"}, {31'h0, busy}, 0);
  endtask

  task automatic run_return(input logic [15:0] fl, input logic [15:0] cs,
                            input logic [15:0] ip, input logic [15:0] ss,
                            input logic [15:0] sp, input string tag);
    exp_mem.push_back('{1'b0, phys(ss, sp), ip, "R8 pop ip"});
    exp_mem.push_back('{1'b0, phys(ss, sp + 16'd2), cs, "R8 pop cs"});
    exp_mem.push_back('{1'b0, phys(ss, sp + 16'd4), fl, "R8 pop flags"});
    exp_reg.push_back('{ip, cs, fl, sp + 16'd6, {tag, " R8"}});
    @(negedge clk);
    ss_in = ss; sp_in = sp; flags_in = 16'h0000; ret_req = 1'b1; boundary = 1'b1;
    @(negedge clk);
    ret_req = 1'b0; boundary = 1'b0;
    chk(busy == 1'b1, {tag, " R1 busy after return strobe"}, {31'h0, busy}, 1);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; boundary = 0; swi_req = 0; nmi_req = 0; irq_req = 0; ret_req = 0;
    irq_type_valid = 0; swi_type = 0; irq_type = 0; mem_ready = 0; mem_rdata = 0;
    flags_in = 0; cs_in = 0; ip_in = 0; ss_in = 0; sp_in = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_valid && !irq_ack, "R11 reset state",
        {28'h0, busy, done, mem_valid, irq_ack}, 0);
    rst_n = 1'b1;

    // R1: held requests without a strobe do nothing
    flags_in = 16'h0200; nmi_req = 1'b1; irq_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 no strobe no start", {31'h0, busy}, 0);
    nmi_req = 1'b0; irq_req = 1'b0;

    // software trigger, type 0x21 -> vectors at 0x84 / 0x86
    run_entry(0, 8'h21, 16'h0302, 16'h1234, 16'h0100, 16'h2000, 16'h0100, 0, 0, 0, "R5 swi 21");
    // maskable, enabled
    run_entry(2, 8'h08, 16'h0246, 16'h4000, 16'h0ABC, 16'h3000, 16'h0F00, 0, 0, 0, "R2 irq 08");
    // R6: masked maskable is ignored
    @(negedge clk);
    flags_in = 16'h0046; irq_req = 1'b1; boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && irq_ack == 1'b0, "R6 masked request ignored",
        {30'h0, busy, irq_ack}, 0);
    irq_req = 1'b0;
    // R6: non-maskable with enable clear, type 2
    run_entry(1, 8'h00, 16'h0146, 16'h5555, 16'h0200, 16'h1000, 16'h0080, 0, 0, 0, "R6 nmi");
    // R7: all three at once -> software type
    run_entry(0, 8'h10, 16'h0200, 16'h0101, 16'h0202, 16'h0800, 16'h0400, 1, 1, 0, "R7 swi wins");
    // R7: non-maskable over maskable
    run_entry(1, 8'h00, 16'h0200, 16'h0303, 16'h0404, 16'h0800, 16'h0400, 0, 1, 0, "R7 nmi wins");
    // R10: strobe with requests mid-sequence is ignored
    run_entry(0, 8'h33, 16'h0000, 16'h0707, 16'h0808, 16'h0900, 16'h0600, 0, 0, 1, "R10 atomic");
    // R12: stack address wraps past 20 bits
    run_entry(0, 8'hFF, 16'h0302, 16'hAAAA, 16'hBBBB, 16'hFFFF, 16'h0020, 0, 0, 0, "R12 wrap");
    // R8: return
    run_return(16'h0246, 16'h1234, 16'h0100, 16'h2000, 16'h00FA, "R8 ret");
    run_return(16'h0302, 16'hAAAA, 16'hBBBB, 16'hFFFF, 16'h001A, "R12 ret wrap");

    repeat (5) @(negedge clk);
    chk(exp_mem.size() == 0 && exp_reg.size() == 0, "R3/R8 scoreboard drained",
        exp_mem.size() + exp_reg.size(), 0);
    finish_run();
  end

endmodule